// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters on a single line that rests high. It runs on the system clock and is paced by an external enable that pulses once per sub-sample period. A bit period is a fixed number of these pulses (the oversampling factor, 4 or 16). The receiver waits for a falling edge on an idle line. It confirms the start bit at its centre, then samples each data bit at its centre, least significant bit first. After the data it takes an optional parity bit and one stop bit.

Each completed character is placed in a single holding register with a valid flag, and a read strobe empties it. Overrun, parity and framing errors are recorded in flags that stay set until a clear pulse. After reset the receiver refuses to start until the line has stayed high for one more bit time than the configured data width. This keeps it from locking onto the middle of a frame that is already in progress.

Top module: `serial_rx`

## Requirements
- R1: After reset `rdValid`, `errOverrun`, `errParity` and `errFraming` are all 0.
- R2: After reset no start bit is accepted until `rxLine` has been high for (N+1)×OVS consecutive sub-sample ticks, where N is 8 when `cfgEightBit`=1 and 7 otherwise. Any low sample restarts that count, and a frame sent earlier produces no character and no flag.
- R3: A received character is presented on `rdData` with the first data bit after the start bit in bit 0, and `rdValid` goes to 1.
- R4: With `cfgEightBit`=0 seven data bits are received into `rdData[6:0]`, and `rdData[7]` reads 0.
- R5: With `cfgParityEn`=1 one parity bit follows the data. `errParity` is set when the XOR of the data bits and the parity bit differs from `cfgParityOdd` (1 selects odd parity, 0 selects even).
- R6: If the line is low at the centre of the stop bit, `errFraming` is set and the character is still delivered.
- R7: If a character completes while `rdValid` is 1 and no read is given, `errOverrun` is set, `rdData` keeps the older character and the new one is dropped.
- R8: A one-cycle `rdStrobe` pulse clears `rdValid`.
- R9: Error flags stay set through later good characters until `errClear` is pulsed. A new error in the clear cycle wins.
- R10: A low pulse that has ended before the centre of the start bit produces no character and no flag, and reception continues normally afterwards.
- R11: A new start bit may directly follow the single stop bit, and that character is received.
- R12: The configuration inputs are taken when the start edge is detected. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| rxLine | input | 1 | Serial input, high when idle |
| baudTick | input | 1 | One-cycle pulse per sub-sample period |
| cfgEightBit | input | 1 | 1: eight data bits, 0: seven |
| cfgParityEn | input | 1 | 1: a parity bit follows the data |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| rdStrobe | input | 1 | Read pulse, empties the holding register |
| errClear | input | 1 | Clears all error flags |
| rdData | output | 8 | Holding register contents |
| rdValid | output | 1 | Holding register full |
| errOverrun | output | 1 | Sticky overrun flag |
| errParity | output | 1 | Sticky parity flag |
| errFraming | output | 1 | Sticky framing flag |

## Verification
The hardest state to reach is the boundary of the post-reset idle wait. A frame must arrive after fewer than N+1 bit times of high line, and the same line must then supply an idle stretch long enough to release the receiver. The bench holds the line high for seven bit times after reset and then sends an all-zero character that must vanish, so its low bits restart the idle count. It then waits ten bit times before sending a character that must arrive. Glitches shorter than half a bit, stop bits forced low, and configuration flips just after the start edge are added as directed cases. These are mixed with seeded random characters across widths and parity modes.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DATA_MAX = 8;
  localparam int IDX_W    = $clog2(DATA_MAX);

  typedef enum logic [2:0] {
    ST_WARM,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, valid for exactly one clock
  typedef struct packed {
    logic             clearShift;
    logic             capData;
    logic             capParity;
    logic             finish;
    logic [IDX_W-1:0] bitIdx;
    logic             parOdd;
  } rxStrobe_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxSync,
  input  logic      cfgEightBit,
  input  logic      cfgParityEn,
  input  logic      cfgParityOdd,
  output rxStrobe_t strobe
);

  localparam int SUB_W    = $clog2(OVS);
  localparam int HALF     = OVS / 2;
  localparam int WARM_MAX = (DATA_MAX + 1) * OVS;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  rxState_t          state;
  logic [SUB_W-1:0]  subCnt;
  logic [WARM_W-1:0] warmCnt;
  logic [WARM_W-1:0] warmTarget;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic              prevLine;
  logic              latEight;
  logic              latParEn;
  logic              latParOdd;
  logic              bitEnd;
  logic              startEdge;

  assign warmTarget = cfgEightBit ? WARM_W'(WARM_MAX) : WARM_W'(DATA_MAX * OVS);
  assign lastIdx    = latEight ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);
  assign bitEnd     = (subCnt == SUB_W'(OVS - 1));
  assign startEdge  = (state == ST_IDLE) && prevLine && !rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_WARM;
      subCnt    <= '0;
      warmCnt   <= '0;
      bitIdx    <= '0;
      prevLine  <= 1'b1;
      latEight  <= 1'b1;
      latParEn  <= 1'b0;
      latParOdd <= 1'b0;
    end else if (baudTick) begin
      case (state)
        ST_WARM: begin
          if (!rxSync) begin
            warmCnt <= '0;
          end else if (warmCnt == warmTarget - 1'b1) begin
            warmCnt  <= '0;
            prevLine <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            warmCnt <= warmCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          prevLine <= rxSync;
          if (startEdge) begin
            subCnt    <= '0;
            latEight  <= cfgEightBit;
            latParEn  <= cfgParityEn;
            latParOdd <= cfgParityOdd;
            state     <= ST_START;
          end
        end
        ST_START: begin
          if (subCnt == SUB_W'(HALF - 1)) begin
            subCnt <= '0;
            bitIdx <= '0;
            if (rxSync) begin
              prevLine <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              state <= ST_DATA;
            end
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            subCnt <= '0;
            if (bitIdx == lastIdx) begin
              state <= latParEn ? ST_PAR : ST_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bitEnd) begin
            subCnt <= '0;
            state  <= ST_STOP;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            subCnt   <= '0;
            prevLine <= rxSync;
            state    <= ST_IDLE;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        default: state <= ST_WARM;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clearShift = baudTick && startEdge;
    strobe.capData    = baudTick && (state == ST_DATA) && bitEnd;
    strobe.capParity  = baudTick && (state == ST_PAR) && bitEnd;
    strobe.finish     = baudTick && (state == ST_STOP) && bitEnd;
    strobe.bitIdx     = bitIdx;
    strobe.parOdd     = latParOdd;
  end

  // R2
  warm_exit_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_WARM) |-> $past(rxSync));

  // R10
  glitch_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && subCnt == SUB_W'(HALF - 1) && rxSync)
      |=> (state == ST_IDLE));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_DATA, ST_PAR, ST_STOP} && $past(state) != ST_IDLE)
      |-> ($stable(latEight) && $stable(latParEn) && $stable(latParOdd)));

endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobe_t           strobe,
  input  logic                rdStrobe,
  input  logic                errClear,
  output logic                rxSync,
  output logic [DATA_MAX-1:0] rdData,
  output logic                rdValid,
  output logic                errOverrun,
  output logic                errParity,
  output logic                errFraming
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_MAX-1:0]    shiftReg;
  logic                   parBad;
  logic                   bufBusy;
  logic                   setOverrun;
  logic                   setParity;
  logic                   setFraming;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg[0] <= 1'b1;
    else       syncReg[0] <= rxLine;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncReg[s] <= 1'b1;
      else       syncReg[s] <= syncReg[s-1];
    end
  end

  assign rxSync = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBad   <= 1'b0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
      parBad   <= 1'b0;
    end else if (strobe.capData) begin
      shiftReg[strobe.bitIdx] <= rxSync;
    end else if (strobe.capParity) begin
      parBad <= ((^shiftReg) ^ rxSync) != strobe.parOdd;
    end
  end

  assign bufBusy    = rdValid && !rdStrobe;
  assign setOverrun = strobe.finish && bufBusy;
  assign setParity  = strobe.finish && parBad;
  assign setFraming = strobe.finish && !rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobe.finish && !bufBusy) begin
      rdData  <= shiftReg;
      rdValid <= 1'b1;
    end else if (rdStrobe) begin
      rdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOverrun <= 1'b0;
      errParity  <= 1'b0;
      errFraming <= 1'b0;
    end else begin
      errOverrun <= setOverrun || (errOverrun && !errClear);
      errParity  <= setParity  || (errParity  && !errClear);
      errFraming <= setFraming || (errFraming && !errClear);
    end
  end

  // R7
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && rdValid && !rdStrobe) |=> errOverrun);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && rdValid && !rdStrobe) |=> ($stable(rdData) && rdValid));

  // R6
  framing_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !rxSync) |=> errFraming);

  // R5
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && parBad) |=> errParity);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strobe.finish) |=> !rdValid);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFraming && !errClear) |=> errFraming);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic                baudTick,
  input  logic                cfgEightBit,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                rdStrobe,
  input  logic                errClear,
  output logic [DATA_MAX-1:0] rdData,
  output logic                rdValid,
  output logic                errOverrun,
  output logic                errParity,
  output logic                errFraming
);

  rxStrobe_t strobe;
  logic      rxSync;

  srx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .baudTick     (baudTick),
    .rxSync       (rxSync),
    .cfgEightBit  (cfgEightBit),
    .cfgParityEn  (cfgParityEn),
    .cfgParityOdd (cfgParityOdd),
    .strobe       (strobe)
  );

  srx_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strobe     (strobe),
    .rdStrobe   (rdStrobe),
    .errClear   (errClear),
    .rxSync     (rxSync),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .errOverrun (errOverrun),
    .errParity  (errParity),
    .errFraming (errFraming)
  );

endmodule

// File: tb/sim_serial_rx.sv
`timescale 1ns/1ps
module sim_serial_rx;

  localparam int OVS    = 16;
  localparam int TDIV   = 2;
  localparam int BITCLK = OVS * TDIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       baudTick = 1'b0;
  logic       cfgEightBit = 1'b1;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       errClear = 1'b0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       errOverrun;
  logic       errParity;
  logic       errFraming;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_rx #(.OVS(OVS)) u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .cfgEightBit(cfgEightBit), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .rdStrobe(rdStrobe), .errClear(errClear), .rdData(rdData), .rdValid(rdValid),
    .errOverrun(errOverrun), .errParity(errParity), .errFraming(errFraming)
  );

  initial begin
    forever begin
      @(negedge clk);
      baudTick = ~baudTick;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expData(input logic [7:0] d, input bit eight);
    return eight ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic parBit(input logic [7:0] d, input bit eight, input bit odd);
    return (^expData(d, eight)) ^ odd;
  endfunction

  task automatic driveBit(input logic v);
    rxLine = v;
    waitClk(BITCLK);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit eight, input bit pEn, input bit pOdd,
                           input bit flipPar, input bit badStop, input bit midFlip);
    cfgEightBit  = eight;
    cfgParityEn  = pEn;
    cfgParityOdd = pOdd;
    driveBit(1'b0);
    if (midFlip) begin
      cfgEightBit  = ~eight;
      cfgParityEn  = ~pEn;
      cfgParityOdd = ~pOdd;
    end
    for (int i = 0; i < (eight ? 8 : 7); i++) driveBit(d[i]);
    if (pEn) driveBit(parBit(d, eight, pOdd) ^ flipPar);
    driveBit(!badStop);
    rxLine       = 1'b1;
    cfgEightBit  = eight;
    cfgParityEn  = pEn;
    cfgParityOdd = pOdd;
  endtask

  task automatic readChar();
    rdStrobe = 1'b1;
    waitClk(1);
    rdStrobe = 1'b0;
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    waitClk(1);
    errClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    waitClk(190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    chk("R1 rdValid", rdValid, 0);
    chk("R1 flags", {errOverrun, errParity, errFraming}, 0);

    // R2 frame before the idle wait completes is ignored
    waitClk(BITCLK * 7);
    sendFrame(8'h00, 1, 0, 0, 0, 0, 0);
    chk("R2 early frame ignored", rdValid, 0);
    chk("R2 no flag", {errOverrun, errParity, errFraming}, 0);
    waitClk(BITCLK * 10);
    sendFrame(8'hA5, 1, 0, 0, 0, 0, 0);
    chk("R2 accepted after idle", rdValid, 1);
    chk("R3 data lsb first", rdData, 8'hA5);
    readChar();
    chk("R8 read clears valid", rdValid, 0);

    // R10 short glitch
    waitClk(BITCLK);
    rxLine = 1'b0;
    waitClk(4);
    rxLine = 1'b1;
    waitClk(BITCLK * 2);
    chk("R10 glitch no char", rdValid, 0);
    chk("R10 glitch no flag", {errOverrun, errParity, errFraming}, 0);
    sendFrame(8'h3C, 1, 0, 0, 0, 0, 0);
    chk("R10 resumes", rdData, 8'h3C);
    readChar();

    // R4 seven-bit mode
    sendFrame(8'hD5, 0, 0, 0, 0, 0, 0);
    chk("R4 seven bit data", rdData, 8'h55);
    readChar();

    // R5 parity, even then odd
    sendFrame(8'h96, 1, 1, 0, 0, 0, 0);
    chk("R5 even good", {rdData, errParity}, {8'h96, 1'b0});
    readChar();
    sendFrame(8'h96, 1, 1, 0, 1, 0, 0);
    chk("R5 even bad", errParity, 1);
    readChar();
    clearErr();
    sendFrame(8'h4B, 0, 1, 1, 0, 0, 0);
    chk("R5 odd good", {rdData, errParity}, {8'h4B, 1'b0});
    readChar();
    sendFrame(8'h4B, 0, 1, 1, 1, 0, 0);
    chk("R5 odd bad", errParity, 1);
    readChar();
    clearErr();

    // R6 framing
    sendFrame(8'h81, 1, 0, 0, 0, 1, 0);
    chk("R6 framing flag", errFraming, 1);
    chk("R6 char delivered", {rdValid, rdData}, {1'b1, 8'h81});
    readChar();
    waitClk(BITCLK);

    // R9 sticky
    sendFrame(8'h11, 1, 0, 0, 0, 0, 0);
    chk("R9 flag stays", errFraming, 1);
    clearErr();
    chk("R9 cleared", errFraming, 0);
    readChar();

    // R7 overrun
    sendFrame(8'h22, 1, 0, 0, 0, 0, 0);
    sendFrame(8'h33, 1, 0, 0, 0, 0, 0);
    chk("R7 overrun flag", errOverrun, 1);
    chk("R7 old data kept", rdData, 8'h22);
    readChar();
    clearErr();
    chk("R7 new char dropped", rdValid, 0);

    // R11 back to back
    sendFrame(8'h44, 1, 0, 0, 0, 0, 0);
    chk("R11 first", rdData, 8'h44);
    readChar();
    sendFrame(8'h5E, 1, 0, 0, 0, 0, 0);
    chk("R11 second", {rdValid, rdData}, {1'b1, 8'h5E});
    readChar();

    // R12 config change mid frame
    sendFrame(8'hC3, 1, 0, 0, 0, 0, 1);
    chk("R12 data intact", rdData, 8'hC3);
    chk("R12 no parity flag", {errParity, errFraming}, 0);
    readChar();

    // R3 R5 random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      bit eight, pEn, pOdd, flip;
      d     = 8'($urandom);
      eight = bit'($urandom % 2);
      pEn   = bit'($urandom % 2);
      pOdd  = bit'($urandom % 2);
      flip  = pEn && (($urandom % 4) == 0);
      waitClk(BITCLK * int'($urandom % 3));
      sendFrame(d, eight, pEn, pOdd, flip, 0, 0);
      chk("R3 random data", {rdValid, rdData}, {1'b1, expData(d, eight)});
      chk("R5 random parity", errParity, flip);
      readChar();
      clearErr();
    end

    finishRun();
  end

endmodule